// File: doc/BRIEF.md
# FIFO-Buffered DMA Transfer Engine

The engine copies a programmed number of 16-bit words between system memory and one memory-mapped peripheral register. All data passes through a small internal FIFO. A host starts a transfer with a single request that supplies four things: a memory start address, a peripheral address, a word count and a direction. The engine then runs without further help and reports either normal completion or a memory fault.

The transfer runs in alternating phases. In the memory-to-peripheral direction, memory is read until the FIFO is full or every word has been fetched. The FIFO is then drained to the peripheral, with one acknowledge handshake per word. After that the engine resumes reading memory at the saved address. The peripheral-to-memory direction is the mirror image: words are collected from the peripheral and then written to memory with both byte lanes enabled. An error response from memory ends the transfer, sets a sticky error flag and flushes the FIFO.

Top module: `fifo_dma_engine`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_en_o`, `dev_wr_o`, `dev_rd_o`, `done_o` and `err_o` are all 0. While the engine waits without a request it stays ready and starts no bus activity.
- R2: A request is accepted on a clock edge where `req_i` and `req_ready_o` are both 1, and all configuration is latched at that edge. One cycle later `req_ready_o` is 0 and `dev_addr_o` equals the latched peripheral address. Later changes on the `cfg_*` inputs have no effect on the running transfer.
- R3: With `cfg_dir_i`=0, memory words are read from consecutive addresses `start`, `start+2`, `start+4`, and so on. They are written to the peripheral in the same order, and `dev_addr_o` stays constant throughout.
- R4: A memory access completes on a cycle where `mem_en_o` and `mem_ready_i` are both 1 and `mem_err_i` is 0. Each completed access advances the memory address by 2.
- R5: The number of words fetched but not yet delivered never exceeds the FIFO depth of 8. A transfer longer than 8 words fills the FIFO completely before the engine switches phase.
- R6: `xfer_ack_o` is 1 exactly in the cycles where a peripheral access is pending and `dev_ack_i` is 1. A transfer of N words produces exactly N peripheral handshakes.
- R7: With `cfg_dir_i`=1, the words accepted from the peripheral are written to consecutive memory addresses from `start`, in order. Each write has `mem_we_o`=2'b11.
- R8: After each phase switch caused by a full FIFO, the memory phase resumes at the address that follows the last completed access. No word is skipped or repeated.
- R9: If `mem_err_i` is 1 during a memory access, the engine abandons the transfer and returns to ready without raising `done_o`. It sets `err_o` and flushes the FIFO. `err_o` stays 1 until the next request is accepted, which clears it.
- R10: After the last word is delivered, `done_o` is 1 for exactly one cycle, and the engine is ready on the next cycle. A word count of 0 completes with `done_o` and no bus access at all.
- R11: While a memory access waits with `mem_ready_i`=0, `mem_en_o` stays 1 and `mem_addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Engine idle, request will be accepted |
| cfg_dir_i | input | 1 | 0: memory to peripheral, 1: peripheral to memory |
| cfg_mem_addr_i | input | 16 | Memory start byte address |
| cfg_dev_addr_i | input | 16 | Peripheral register address |
| cfg_words_i | input | 8 | Number of words to transfer |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 2 | Byte-lane write enables (2'b11 on write) |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory access completes this cycle |
| mem_err_i | input | 1 | Memory access fault |
| dev_addr_o | output | 16 | Peripheral register address |
| dev_wr_o | output | 1 | Peripheral write pending |
| dev_rd_o | output | 1 | Peripheral read pending |
| dev_wdata_o | output | 16 | Peripheral write data |
| dev_rdata_i | input | 16 | Peripheral read data, valid with dev_ack_i |
| dev_ack_i | input | 1 | Peripheral acknowledge |
| xfer_ack_o | output | 1 | Engine acknowledge of a completed peripheral word |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Sticky memory error flag |

## Verification
Most effort goes into transfers of 20 words, which cross the full-FIFO switch twice under random ready and acknowledge gaps. An engine that resumed at a stale address, or that dropped the word landing on the full boundary, would deliver a peripheral sequence with a gap or a duplicate. A long memory stall checks that the address is held steady while waiting; an engine that advanced early would skip words. The error case injects a fault after three words are already buffered, then runs a fresh transfer. An engine that did not flush would send those stale words to the peripheral, and one that cleared the flag too early or too late would show the wrong `err_o`. A zero-length request checks that completion does not depend on any bus traffic.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CFG, ST_MEM_RD, ST_DEV_WR, ST_DEV_RD,
    ST_MEM_WR, ST_RESUME, ST_DONE, ST_ERR
  } dma_state_e;

  localparam logic DIR_MEM2DEV = 1'b0;
  localparam logic [1:0] WE_BOTH = 2'b11;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q, cnt_d;

  assign cnt_d = cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      full_o <= 1'b0; empty_o <= 1'b1;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      full_o <= 1'b0; empty_o <= 1'b1;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q   <= cnt_d;
      full_o  <= (cnt_d == (PW+1)'(DEPTH));
      empty_o <= (cnt_d == '0);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  assert_no_push_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0] cur_q, saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0; saved_q <= '0;
    end else if (load_i) begin
      cur_q <= load_val_i; saved_q <= load_val_i;
    end else if (clr_i) begin
      cur_q <= '0; saved_q <= '0;
    end else begin
      if (restore_i)   cur_q <= saved_q;   // resume mux
      else if (step_i) cur_q <= cur_q + STEP;
      if (save_i)      saved_q <= cur_q;
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          cfg_dir_i,
  input  logic [CW-1:0] cfg_words_i,
  output logic          req_ready_o,
  output logic          cfg_load_o,
  output logic          clr_o,
  output logic          dir_o,
  output logic          mem_en_o,
  output logic          mem_wr_o,
  input  logic          mem_ready_i,
  input  logic          mem_err_i,
  output logic          dev_wr_o,
  output logic          dev_rd_o,
  input  logic          dev_ack_i,
  output logic          xfer_ack_o,
  output logic          fifo_push_o,
  output logic          fifo_pop_o,
  output logic          fifo_flush_o,
  input  logic          fifo_full_i,
  input  logic          fifo_empty_i,
  output logic          addr_step_o,
  output logic          addr_save_o,
  output logic          addr_restore_o,
  output logic          done_o,
  output logic          err_o
);
  dma_state_e st_q, st_d;
  logic [CW-1:0] total_q, in_cnt_q, out_cnt_q;
  logic in_inc, out_inc, in_all, out_all;

  assign in_all  = (in_cnt_q == total_q);
  assign out_all = (out_cnt_q == total_q);

  always_comb begin
    st_d = st_q;
    {req_ready_o, cfg_load_o, clr_o, mem_en_o, mem_wr_o, dev_wr_o, dev_rd_o} = '0;
    {xfer_ack_o, fifo_push_o, fifo_pop_o, fifo_flush_o} = '0;
    {addr_step_o, addr_save_o, addr_restore_o, in_inc, out_inc} = '0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready_o = 1'b1; clr_o = 1'b1; fifo_flush_o = 1'b1;
        if (req_i) begin cfg_load_o = 1'b1; st_d = ST_CFG; end
      end
      ST_CFG: st_d = dir_o ? ST_DEV_RD : ST_MEM_RD;
      ST_MEM_RD: begin
        if (fifo_full_i || in_all) begin
          addr_save_o = 1'b1; st_d = ST_DEV_WR;
        end else begin
          mem_en_o = 1'b1;
          if (mem_err_i) st_d = ST_ERR;
          else if (mem_ready_i) begin
            fifo_push_o = 1'b1; addr_step_o = 1'b1; in_inc = 1'b1;
          end
        end
      end
      ST_DEV_WR: begin
        if (fifo_empty_i) st_d = out_all ? ST_DONE : ST_RESUME;
        else begin
          dev_wr_o = 1'b1;
          if (dev_ack_i) begin xfer_ack_o = 1'b1; fifo_pop_o = 1'b1; out_inc = 1'b1; end
        end
      end
      ST_DEV_RD: begin
        if (fifo_full_i || in_all) st_d = ST_MEM_WR;
        else begin
          dev_rd_o = 1'b1;
          if (dev_ack_i) begin xfer_ack_o = 1'b1; fifo_push_o = 1'b1; in_inc = 1'b1; end
        end
      end
      ST_MEM_WR: begin
        if (fifo_empty_i) begin
          addr_save_o = 1'b1; st_d = out_all ? ST_DONE : ST_RESUME;
        end else begin
          mem_en_o = 1'b1; mem_wr_o = 1'b1;
          if (mem_err_i) st_d = ST_ERR;
          else if (mem_ready_i) begin
            fifo_pop_o = 1'b1; addr_step_o = 1'b1; out_inc = 1'b1;
          end
        end
      end
      ST_RESUME: begin
        addr_restore_o = 1'b1; st_d = dir_o ? ST_DEV_RD : ST_MEM_RD;
      end
      ST_DONE: st_d = ST_IDLE;
      ST_ERR: begin fifo_flush_o = 1'b1; st_d = ST_IDLE; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; total_q <= '0; dir_o <= DIR_MEM2DEV;
      in_cnt_q <= '0; out_cnt_q <= '0; err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cfg_load_o) begin
        total_q <= cfg_words_i; dir_o <= cfg_dir_i; err_o <= 1'b0;
      end else if (clr_o) total_q <= '0;
      if (st_q == ST_ERR) err_o <= 1'b1;
      if (clr_o) begin
        in_cnt_q <= '0; out_cnt_q <= '0;
      end else begin
        if (in_inc)  in_cnt_q  <= in_cnt_q + 1'b1;
        if (out_inc) out_cnt_q <= out_cnt_q + 1'b1;
      end
    end
  end

  assign done_o = (st_q == ST_DONE);

  assert_stay_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && !req_i |=> req_ready_o && !mem_en_o);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_i |=> !req_ready_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !(req_i && req_ready_o) |=> err_o);
  assert_xfer_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |-> dev_ack_i && (dev_wr_o || dev_rd_o));
endmodule

// File: rtl/fifo_dma_engine.sv
module fifo_dma_engine
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          req_ready_o,
  input  logic          cfg_dir_i,
  input  logic [AW-1:0] cfg_mem_addr_i,
  input  logic [AW-1:0] cfg_dev_addr_i,
  input  logic [CW-1:0] cfg_words_i,
  output logic          mem_en_o,
  output logic [1:0]    mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  input  logic          mem_err_i,
  output logic [AW-1:0] dev_addr_o,
  output logic          dev_wr_o,
  output logic          dev_rd_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic [DW-1:0] dev_rdata_i,
  input  logic          dev_ack_i,
  output logic          xfer_ack_o,
  output logic          done_o,
  output logic          err_o
);
  logic cfg_load, clr, dir, mem_wr;
  logic push, pop, flush, full, empty;
  logic step, save, restore;
  logic [DW-1:0] head;

  dma_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .cfg_dir_i, .cfg_words_i,
    .req_ready_o, .cfg_load_o(cfg_load), .clr_o(clr), .dir_o(dir),
    .mem_en_o, .mem_wr_o(mem_wr), .mem_ready_i, .mem_err_i,
    .dev_wr_o, .dev_rd_o, .dev_ack_i, .xfer_ack_o,
    .fifo_push_o(push), .fifo_pop_o(pop), .fifo_flush_o(flush),
    .fifo_full_i(full), .fifo_empty_i(empty),
    .addr_step_o(step), .addr_save_o(save), .addr_restore_o(restore),
    .done_o, .err_o
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push),
    .wdata_i(dir ? dev_rdata_i : mem_rdata_i),
    .pop_i(pop), .rdata_o(head), .full_o(full), .empty_o(empty)
  );

  dma_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(cfg_load), .load_val_i(cfg_mem_addr_i),
    .step_i(step), .save_i(save), .restore_i(restore), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dev_addr_o <= '0;
    else if (cfg_load) dev_addr_o <= cfg_dev_addr_i;
    else if (clr)      dev_addr_o <= '0;
  end

  assign mem_we_o    = mem_wr ? WE_BOTH : 2'b00;
  assign mem_wdata_o = head;
  assign dev_wdata_o = head;

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !mem_ready_i && !mem_err_i |=> mem_en_o && $stable(mem_addr_o));
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_ready_i && !mem_err_i |=> mem_addr_o == $past(mem_addr_o) + AW'(2));
  assert_we_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_we_o == WE_BOTH |-> !empty && dir);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

// File: tb/test_fifo_dma_engine.sv
module test_fifo_dma_engine;
  localparam int AW = 16, DW = 16, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req, req_ready, cfg_dir;
  logic [AW-1:0] cfg_mem, cfg_dev, mem_addr, dev_addr;
  logic [CW-1:0] cfg_words;
  logic mem_en, mem_ready, mem_err, dev_wr, dev_rd, dev_ack, xfer_ack, done, err;
  logic [1:0] mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;

  fifo_dma_engine i_fifo_dma_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_ready_o(req_ready),
    .cfg_dir_i(cfg_dir), .cfg_mem_addr_i(cfg_mem), .cfg_dev_addr_i(cfg_dev),
    .cfg_words_i(cfg_words), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .mem_err_i(mem_err), .dev_addr_o(dev_addr),
    .dev_wr_o(dev_wr), .dev_rd_o(dev_rd), .dev_wdata_o(dev_wdata),
    .dev_rdata_i(dev_rdata), .dev_ack_i(dev_ack), .xfer_ack_o(xfer_ack),
    .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] mem_m [256];
  logic [DW-1:0] dev_log [256];
  int mem_rd_n, mem_wr_n, dev_wr_n, dev_rd_n, occ_max;
  int ack_bad, addr_bad, stall_bad, devaddr_bad, src_idx, src_base, err_at;
  logic [AW-1:0] exp_base, exp_dev, prev_addr;
  logic [1:0] rmode, amode;
  logic [7:0] lf;
  logic err_arm, prev_stall, rgate, agate;

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 309) ^ 16'hC300;
  endfunction

  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  always @(posedge clk) if (dev_rd && dev_ack) src_idx <= src_idx + 1;

  always_comb begin
    rgate = (rmode == 2'd0) ? 1'b1 : (rmode == 2'd1) ? lf[0] : (lf[2:1] == 2'b00);
    agate = (amode == 2'd0) ? 1'b1 : (amode == 2'd1) ? lf[4] : (lf[6:5] == 2'b00);
  end

  assign mem_err   = mem_en && err_arm && (mem_rd_n >= err_at);
  assign mem_ready = mem_en && !mem_err && rgate;
  assign mem_rdata = mem_m[mem_addr[8:1]];
  assign dev_ack   = (dev_wr || dev_rd) && agate;
  assign dev_rdata = pat(src_idx);

  always @(negedge clk) if (rst_n) begin
    if (xfer_ack != dev_ack) ack_bad++;
    if (prev_stall && (!mem_en || mem_addr != prev_addr)) stall_bad++;
    prev_stall = mem_en && !mem_ready && !mem_err;
    prev_addr  = mem_addr;
    if (mem_en && mem_ready) begin
      if (mem_we == 2'b11) begin
        if (mem_addr != exp_base + AW'(2 * mem_wr_n)) addr_bad++;
        mem_m[mem_addr[8:1]] = mem_wdata; mem_wr_n++;
      end else begin
        if (mem_addr != exp_base + AW'(2 * mem_rd_n)) addr_bad++;
        mem_rd_n++;
      end
    end
    if (dev_wr && dev_ack) begin
      if (dev_addr != exp_dev) devaddr_bad++;
      dev_log[dev_wr_n] = dev_wdata; dev_wr_n++;
    end
    if (dev_rd && dev_ack) begin
      if (dev_addr != exp_dev) devaddr_bad++;
      dev_rd_n++;
    end
    if (mem_rd_n - dev_wr_n > occ_max) occ_max = mem_rd_n - dev_wr_n;
    if (dev_rd_n - mem_wr_n > occ_max) occ_max = dev_rd_n - mem_wr_n;
  end

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run_xfer(bit dir, logic [AW-1:0] base, logic [AW-1:0] dv, int n,
                          output bit done_seen);
    @(posedge clk);
    mem_rd_n = 0; mem_wr_n = 0; dev_wr_n = 0; dev_rd_n = 0; occ_max = 0;
    ack_bad = 0; addr_bad = 0; stall_bad = 0; devaddr_bad = 0;
    exp_base = base; exp_dev = dv;
    @(negedge clk);
    src_base = src_idx;
    req = 1'b1; cfg_dir = dir; cfg_mem = base; cfg_dev = dv; cfg_words = CW'(n);
    @(negedge clk);
    req = 1'b0; cfg_dir = ~dir; cfg_mem = 16'hFFF0; cfg_dev = 16'h0BAD; cfg_words = 8'd3;
    chk(!req_ready, "R2 busy after accept", int'(req_ready), 0);
    chk(dev_addr == dv, "R2 latched dev addr", int'(dev_addr), int'(dv));
    chk(!err, "R9 flag cleared by accept", int'(err), 0);
    done_seen = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin done_seen = 1'b1; break; end
      if (req_ready) break;
      @(negedge clk);
      if (c == 2999) chk(1'b0, "R10 transfer timeout", c, 0);
    end
    if (done_seen) begin
      @(negedge clk);
      chk(!done && req_ready, "R10 single done pulse", int'(done), 0);
    end
    @(posedge clk);
  endtask

  task automatic check_m2d(int n, logic [AW-1:0] base, string rq);
    int bad = 0;
    for (int i = 0; i < n; i++) if (dev_log[i] != mem_m[base[8:1] + 8'(i)]) bad++;
    chk(bad == 0, rq, bad, 0);
    chk(dev_wr_n == n && mem_rd_n == n, "R6 word handshakes", dev_wr_n, n);
    chk(ack_bad == 0, "R6 xfer_ack alignment", ack_bad, 0);
    chk(addr_bad == 0, "R4 address step", addr_bad, 0);
    chk(devaddr_bad == 0, "R3 constant dev addr", devaddr_bad, 0);
  endtask

  task automatic t_reset();
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    chk(!mem_en && !dev_wr && !dev_rd, "R1 no bus activity", int'(mem_en), 0);
    chk(!done && !err, "R1 flags clear", int'(err), 0);
  endtask

  task automatic t_m2d_short();
    bit d;
    rmode = 0; amode = 0;
    run_xfer(1'b0, 16'h0010, 16'h4000, 6, d);
    chk(d, "R10 done short", int'(d), 1);
    check_m2d(6, 16'h0010, "R3 data order short");
  endtask

  task automatic t_m2d_long();
    bit d;
    rmode = 1; amode = 1;
    run_xfer(1'b0, 16'h0040, 16'h4002, 20, d);
    chk(d, "R10 done long", int'(d), 1);
    check_m2d(20, 16'h0040, "R8 data across resumes");
    chk(occ_max == 8, "R5 fifo fill bound", occ_max, 8);
  endtask

  task automatic t_d2m();
    bit d;
    int bad = 0;
    rmode = 1; amode = 2;
    run_xfer(1'b1, 16'h0100, 16'h4004, 13, d);
    chk(d, "R10 done d2m", int'(d), 1);
    for (int i = 0; i < 13; i++) if (mem_m[8'h80 + 8'(i)] != pat(src_base + i)) bad++;
    chk(bad == 0, "R7 memory contents", bad, 0);
    chk(mem_wr_n == 13 && dev_rd_n == 13, "R7 word count", mem_wr_n, 13);
    chk(addr_bad == 0, "R7 write addresses", addr_bad, 0);
    chk(occ_max <= 8, "R5 bound d2m", occ_max, 8);
  endtask

  task automatic t_stall();
    bit d;
    rmode = 2; amode = 0;
    run_xfer(1'b0, 16'h0020, 16'h4006, 5, d);
    chk(stall_bad == 0, "R11 address held in stall", stall_bad, 0);
    check_m2d(5, 16'h0020, "R11 data under stall");
  endtask

  task automatic t_zero();
    bit d;
    rmode = 0; amode = 0;
    run_xfer(1'b0, 16'h0030, 16'h4008, 0, d);
    chk(d, "R10 zero count done", int'(d), 1);
    chk(mem_rd_n + dev_wr_n == 0, "R10 zero count no access", mem_rd_n + dev_wr_n, 0);
  endtask

  task automatic t_error();
    bit d;
    rmode = 0; amode = 0; err_at = 3; err_arm = 1'b1;
    run_xfer(1'b0, 16'h0060, 16'h400A, 10, d);
    err_arm = 1'b0;
    chk(!d, "R9 no done on error", int'(d), 0);
    chk(err && req_ready, "R9 error flag and idle", int'(err), 1);
    chk(dev_wr_n == 0, "R9 nothing sent", dev_wr_n, 0);
    repeat (3) @(negedge clk);
    chk(err, "R9 flag sticky", int'(err), 1);
    run_xfer(1'b0, 16'h0070, 16'h400C, 4, d);
    chk(d, "R9 recovery done", int'(d), 1);
    check_m2d(4, 16'h0070, "R9 fifo flushed");
  endtask

  initial begin
    req = 0; cfg_dir = 0; cfg_mem = '0; cfg_dev = '0; cfg_words = '0;
    rmode = 0; amode = 0; lf = 8'h5B; err_arm = 1'b0; err_at = 0; src_idx = 0;
    prev_stall = 1'b0; prev_addr = '0; exp_base = '0; exp_dev = '0;
    for (int i = 0; i < 256; i++) mem_m[i] = DW'(16'h1000 + i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_m2d_short();
    t_m2d_long();
    t_d2m();
    t_stall();
    t_zero();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule